// File: doc/BRIEF.md
# Teletext Request Window Generator

This block tells an external teletext data source when to send its bitstream. It watches the current line number, the field parity and the horizontal pixel position of the video timing chain. It raises a single request pin only on lines that fall inside a programmed line window, and only between a programmed start and stop position on each of those lines. The odd field and the even field each have their own first-line and last-line registers.

A register value does not name a line directly. The block adds a fixed offset to it, and that offset depends on the line standard: 4 for the 525-line standard and 1 for the 625-line standard. The standard select is captured once per field, on the field-start strobe, so a change part way through a field waits for the next field. The horizontal start value is chosen so that the request leads the point where the data must appear in the line (for example 9.78 us after the sync leading edge in 625-line mode) by the downstream interpolation latency. A global enable turns the request off completely.

All inputs are plain control and timing signals. There is no data stream at the edge of the block, so there is no valid/ready handshake. The output is a registered level that changes only on a clock edge.

Top module: `ttx_req_gen`

## Requirements
- R1: While reset is applied and in the first cycle after it, `ttx_req` is 0. The captured standard resets to 625-line.
- R2: `ttx_req` is 1 in the cycle after a clock edge at which all three hold: `ttx_en`=1, the line is selected, and `h_start` <= `hpos` < `h_stop`. Otherwise it is 0.
- R3: When `field_odd`=1 the odd-field registers (`odd_first`, `odd_last`) select the lines. When `field_odd`=0 the even-field registers (`even_first`, `even_last`) select them.
- R4: The line offset added to both the first and last register is 4 when the captured standard is 525-line (`std_525`=1) and 1 when it is 625-line (`std_525`=0).
- R5: A line is selected when first+offset <= `line_num` <= last+offset. Both ends are included.
- R6: If the first register is greater than the last register for the current field, no line is selected.
- R7: With `ttx_en`=0 no request is produced, whatever the other inputs are.
- R8: `std_525` is captured on a cycle where `field_start`=1, and the value is already used in that same cycle. On other cycles the held value is used, so a change in the middle of a field has no effect until the next `field_start`.
- R9: If `h_start` >= `h_stop`, no request is produced on any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ttx_en | input | 1 | Global request enable |
| std_525 | input | 1 | 1 = 525-line standard, 0 = 625-line standard |
| field_start | input | 1 | One-cycle strobe at the first pixel of a field |
| field_odd | input | 1 | 1 = odd field, 0 = even field |
| line_num | input | LINE_W | Current line number |
| hpos | input | H_W | Current horizontal pixel position |
| odd_first | input | LINE_W | Odd-field first-line register |
| odd_last | input | LINE_W | Odd-field last-line register |
| even_first | input | LINE_W | Even-field first-line register |
| even_last | input | LINE_W | Even-field last-line register |
| h_start | input | H_W | Horizontal position where the request rises |
| h_stop | input | H_W | Horizontal position where the request falls |
| ttx_req | output | 1 | Registered request to the teletext source |

## Verification
Capture of the standard and the line-window decision can happen in the same cycle. That occurs when `field_start` arrives on a line that sits at the edge of the window. The bench provokes this by starting a field on line 1 with a first-line register of 0 and `h_start` of 0, while switching `std_525` on the strobe itself. The reference model applies the newly presented standard in that cycle, so line 1 must not request under the 525-line offset, where it would under the 625-line offset. A later field then flips `std_525` in mid-field and checks that the window stays where the captured standard put it.

// File: rtl/ttx_pkg.sv
package ttx_pkg;
  typedef enum logic {STD_625 = 1'b0, STD_525 = 1'b1} line_std_e;

  localparam int unsigned OFS_W   = 3;
  localparam int unsigned OFS_525 = 4;
  localparam int unsigned OFS_625 = 1;

  function automatic logic [OFS_W-1:0] line_offset(input line_std_e s);
    return (s == STD_525) ? OFS_W'(OFS_525) : OFS_W'(OFS_625);
  endfunction
endpackage

// File: rtl/ttx_std_track.sv
module ttx_std_track
  import ttx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             field_start,
  input  logic             std_525,
  output logic [OFS_W-1:0] ofs
);
  line_std_e std_q;
  line_std_e std_eff;

  // The strobe cycle already uses the newly presented standard
  assign std_eff = field_start ? line_std_e'(std_525) : std_q;
  assign ofs     = line_offset(std_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           std_q <= STD_625;
    else if (field_start) std_q <= line_std_e'(std_525);
  end

  assert_std_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !field_start |=> $stable(std_q));
endmodule

// File: rtl/ttx_line_window.sv
module ttx_line_window
  import ttx_pkg::*;
#(
  parameter int unsigned LINE_W = 10
) (
  input  logic [LINE_W-1:0] first,
  input  logic [LINE_W-1:0] last,
  input  logic [LINE_W-1:0] line,
  input  logic [OFS_W-1:0]  ofs,
  output logic              sel
);
  localparam int unsigned EW = LINE_W + 1;

  logic [EW-1:0] first_x, last_x, line_x, ofs_x;

  // One extra bit so that adding the offset cannot wrap
  assign ofs_x   = EW'(ofs);
  assign first_x = {1'b0, first} + ofs_x;
  assign last_x  = {1'b0, last}  + ofs_x;
  assign line_x  = {1'b0, line};

  assign sel = (first <= last) && (line_x >= first_x) && (line_x <= last_x);
endmodule

// File: rtl/ttx_hgate.sv
module ttx_hgate #(
  parameter int unsigned H_W = 11
) (
  input  logic [H_W-1:0] hpos,
  input  logic [H_W-1:0] h_start,
  input  logic [H_W-1:0] h_stop,
  output logic           open_now
);
  // Start is inclusive, stop is exclusive
  assign open_now = (hpos >= h_start) && (hpos < h_stop);
endmodule

// File: rtl/ttx_req_gen.sv
module ttx_req_gen
  import ttx_pkg::*;
#(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned H_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ttx_en,
  input  logic              std_525,
  input  logic              field_start,
  input  logic              field_odd,
  input  logic [LINE_W-1:0] line_num,
  input  logic [H_W-1:0]    hpos,
  input  logic [LINE_W-1:0] odd_first,
  input  logic [LINE_W-1:0] odd_last,
  input  logic [LINE_W-1:0] even_first,
  input  logic [LINE_W-1:0] even_last,
  input  logic [H_W-1:0]    h_start,
  input  logic [H_W-1:0]    h_stop,
  output logic              ttx_req
);
  localparam int unsigned N_FIELDS = 2;

  logic [OFS_W-1:0]  ofs;
  logic [LINE_W-1:0] first_a [N_FIELDS];
  logic [LINE_W-1:0] last_a  [N_FIELDS];
  logic [N_FIELDS-1:0] fsel;
  logic h_open, line_ok, req_d;

  // Index 0 holds the even field, index 1 the odd field
  assign first_a[0] = even_first;
  assign last_a[0]  = even_last;
  assign first_a[1] = odd_first;
  assign last_a[1]  = odd_last;

  ttx_std_track u_std (
    .clk(clk), .rst_n(rst_n), .field_start(field_start),
    .std_525(std_525), .ofs(ofs)
  );

  for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
    ttx_line_window #(.LINE_W(LINE_W)) u_win (
      .first(first_a[f]), .last(last_a[f]), .line(line_num),
      .ofs(ofs), .sel(fsel[f])
    );
  end

  ttx_hgate #(.H_W(H_W)) u_hg (
    .hpos(hpos), .h_start(h_start), .h_stop(h_stop), .open_now(h_open)
  );

  assign line_ok = field_odd ? fsel[1] : fsel[0];
  assign req_d   = ttx_en && line_ok && h_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ttx_req <= 1'b0;
    else        ttx_req <= req_d;
  end

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ttx_en |=> !ttx_req);
  assert_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hpos < h_start) |=> !ttx_req);
  assert_empty_hwin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (h_start >= h_stop) |=> !ttx_req);
  assert_odd_inverted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (field_odd && odd_first > odd_last) |=> !ttx_req);
  assert_even_inverted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!field_odd && even_first > even_last) |=> !ttx_req);
endmodule

// File: tb/ttx_req_gen_tb_top.sv
module ttx_req_gen_tb_top;
  localparam int LW = 10;
  localparam int HW = 11;
  localparam int HLEN = 10;
  localparam int NLINES = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ttx_en = 1'b0, std_525 = 1'b0, field_start = 1'b0, field_odd = 1'b1;
  logic [LW-1:0] line_num = '0, odd_first = '0, odd_last = '0, even_first = '0, even_last = '0;
  logic [HW-1:0] hpos = '0, h_start = '0, h_stop = '0;
  logic ttx_req;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;
  bit checking = 1'b0;
  bit exp_req = 1'b0;
  int std_m = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  ttx_req_gen #(.LINE_W(LW), .H_W(HW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ttx_en(ttx_en), .std_525(std_525),
    .field_start(field_start), .field_odd(field_odd), .line_num(line_num),
    .hpos(hpos), .odd_first(odd_first), .odd_last(odd_last),
    .even_first(even_first), .even_last(even_last),
    .h_start(h_start), .h_stop(h_stop), .ttx_req(ttx_req)
  );

  // Behavioural reference model
  always @(posedge clk) begin
    int eff, off, fi, la, ln, hp;
    if (!rst_n) begin
      exp_req = 1'b0;
      std_m = 0;
    end else begin
      eff = field_start ? int'(std_525) : std_m;
      off = (eff != 0) ? 4 : 1;
      fi = field_odd ? int'(odd_first) : int'(even_first);
      la = field_odd ? int'(odd_last) : int'(even_last);
      ln = int'(line_num);
      hp = int'(hpos);
      exp_req = ttx_en && (fi <= la) && (ln >= fi + off) && (ln <= la + off)
                && (hp >= int'(h_start)) && (hp < int'(h_stop));
      if (field_start) std_m = int'(std_525);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (checking) begin
      vectors++;
      if (ttx_req !== exp_req) begin
        miscompares++;
        $display("FAIL %s: ttx_req actual %0b expected %0b (line %0d hpos %0d)",
                 tag, ttx_req, exp_req, line_num, hpos);
      end
    end
  end

  task automatic run_field(input bit odd, input bit std_at_start,
                           input int flip_line);
    for (int ln = 1; ln <= NLINES; ln++) begin
      for (int hp = 0; hp < HLEN; hp++) begin
        @(negedge clk);
        field_odd = odd;
        line_num = LW'(ln);
        hpos = HW'(hp);
        field_start = (ln == 1 && hp == 0);
        if (ln == 1 && hp == 0) std_525 = std_at_start;
        else if (ln == flip_line && hp == 0) std_525 = ~std_at_start;
      end
    end
    @(negedge clk);
    field_start = 1'b0;
    hpos = '0;
    line_num = '0;
  endtask

  initial begin
    checking = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tag = "R1";
    vectors++;
    if (ttx_req !== 1'b0) begin
      miscompares++;
      $display("FAIL R1: ttx_req actual %0b expected 0 after reset", ttx_req);
    end
    ttx_en = 1'b1;
    h_start = 2; h_stop = 7;
    // R2 R4 R5: 625-line odd window, lines 3..6 inclusive
    tag = "R2/R4/R5";
    odd_first = 2; odd_last = 5; even_first = 0; even_last = 1;
    run_field(1'b1, 1'b0, 0);
    // R3: even field uses its own registers, lines 1..2
    tag = "R3";
    run_field(1'b0, 1'b0, 0);
    // R4: 525-line offset, lines 6..9
    tag = "R4";
    run_field(1'b1, 1'b1, 0);
    // R8: mid-field flip to 525 must be ignored
    tag = "R8";
    run_field(1'b1, 1'b0, 4);
    // R8: strobe-cycle capture with window edge at line 1
    tag = "R8";
    odd_first = 0; odd_last = 3; h_start = 0;
    run_field(1'b1, 1'b0, 0);
    run_field(1'b1, 1'b1, 0);
    // R6: inverted window
    tag = "R6";
    odd_first = 5; odd_last = 3;
    run_field(1'b1, 1'b0, 0);
    // R7: enable off
    tag = "R7";
    odd_first = 0; odd_last = 8; ttx_en = 1'b0;
    run_field(1'b1, 1'b0, 0);
    // R9: empty horizontal window
    tag = "R9";
    ttx_en = 1'b1; h_start = 5; h_stop = 5;
    run_field(1'b1, 1'b0, 0);
    h_start = 6; h_stop = 3;
    run_field(1'b0, 1'b1, 0);
    // R2: wide horizontal window to end of line
    tag = "R2";
    h_start = 1; h_stop = HW'(HLEN);
    run_field(1'b0, 1'b0, 0);
    @(negedge clk);
    checking = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checking = 1'b0;
    miscompares++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule